// File: doc/BRIEF.md
# Sample FIFO with Threshold Control

This block sits between the sample source of a data-acquisition channel and the host. Each incoming sample is a 24-bit two's-complement value with a 5-bit channel number. The block cuts the sample down to the selected width and codes it in offset binary or two's complement. It stores the coded value and the channel number together as one 32-bit word in a deep first-in first-out buffer. The host takes words out with a pop strobe.

The host controls the block through one 32-bit register. The register holds a level threshold, an input-block bit, a clear command that drops back to zero by itself, and a width selector. It also holds two sticky error flags: one for a sample that arrives while the buffer is full, and one for a pop while the buffer is empty. A registered status output rises whenever the fill count is above the threshold. The buffer depth is a parameter. The full-size part holds 262,144 words, and simulation uses a much smaller depth.

Top module: `sample_fifo_ctl`

## Requirements
- R1: After reset, fill_count is 0 and thresh_flag is 0. reg_rdata reads 0x0003FFFE: threshold 0x3FFFE, every other field 0. pop_data reads 0.
- R2: Accepted samples come out in arrival order. Each popped word has bits [31:29] = 0, the channel number in bits [28:24] and the coded sample in bits [23:0]. pop_data is valid one cycle after the pop.
- R3: The width field, reg bits [21:20], selects the stored width as 0 = 16, 1 = 18, 2 = 20 or 3 = 24 bits. The upper W bits of the 24-bit sample are kept, right-justified in bits [W-1:0], and the bits above them are zero. The width in force when a sample arrives is the one used.
- R4: With offset_bin low the kept bits are stored unchanged (two's complement). With offset_bin high, bit W-1 is inverted (offset binary), so a zero sample is stored as 1 followed by zeros.
- R5: Threshold bits [17:0] are compared with the fill count. thresh_flag is 1 exactly when fill_count is strictly greater than the threshold, and it follows fill_count and threshold writes with the same one-cycle latency.
- R6: While bit 18 is 1, incoming samples are dropped and fill_count does not change.
- R7: Writing bit 19 high empties the buffer at that clock edge. Bit 19 then reads 1 for exactly one cycle and returns to 0 by itself. The two error flags are left unchanged.
- R8: A sample that arrives while the buffer is full (DEPTH words) is discarded and sets bit 24. The stored words are left intact.
- R9: A pop while the buffer is empty returns 0 on pop_data and sets bit 25. The read position does not move.
- R10: Bits 24 and 25 stay set until a register write puts 0 in them. Writing 1 to either bit leaves it unchanged and never sets it.
- R11: Bits [23:22] and [31:26] of reg_rdata always read 0.
- R12: fill_count rises by one for each accepted sample and falls by one for each successful pop. It is unchanged when both happen in the same cycle, and it never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offset_bin | input | 1 | 1 = store in offset binary, 0 = two's complement |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 5 | Channel number of the sample |
| smp_data | input | 24 | Raw two's-complement sample |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Control register write value |
| reg_rdata | output | 32 | Control register readback |
| pop | input | 1 | Take one word from the buffer |
| pop_data | output | 32 | Word taken by the previous pop |
| fill_count | output | $clog2(DEPTH)+1 | Number of stored words |
| thresh_flag | output | 1 | Fill count above threshold |

## Verification
fill_count, thresh_flag and reg_rdata all change at the clock edge that takes the sample, pop or register write. The clear bit stays high only until the following edge. pop_data is loaded at the edge that takes the pop. The bench changes inputs on the falling edge, holds them across one rising edge, and reads results on the next falling edge, so every check falls in the cycle where its result is first due. The clear test reads the register on two falling edges in a row, to show bit 19 high for one cycle and then low.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int RAW_W  = 24;
  localparam int TAG_W  = 5;
  localparam int WORD_W = 32;
  localparam int THR_W  = 18;
  localparam int TAG_LSB = 24;

  // control register bit positions
  localparam int DIS_BIT = 18;
  localparam int CLR_BIT = 19;
  localparam int WID_LSB = 20;
  localparam int OVF_BIT = 24;
  localparam int UNF_BIT = 25;

  localparam logic [THR_W-1:0] THR_RST = 18'h3FFFE;

  typedef enum logic [1:0] {WID_16 = 2'd0, WID_18 = 2'd1, WID_20 = 2'd2, WID_24 = 2'd3} wid_e;

  typedef struct packed {
    logic             unf;
    logic             ovf;
    wid_e             wid;
    logic             clr;
    logic             dis;
    logic [THR_W-1:0] thr;
  } ctrl_t;
endpackage

// File: rtl/sfc_coder.sv
module sfc_coder
  import sfc_pkg::*;
(
  input  logic [RAW_W-1:0] raw_i,
  input  wid_e             wid_i,
  input  logic             offset_i,
  output logic [RAW_W-1:0] code_o
);
  always_comb begin
    code_o = '0;
    unique case (wid_i)
      WID_16: begin
        code_o[15:0] = raw_i[RAW_W-1 -: 16];
        code_o[15]   = raw_i[RAW_W-1] ^ offset_i;
      end
      WID_18: begin
        code_o[17:0] = raw_i[RAW_W-1 -: 18];
        code_o[17]   = raw_i[RAW_W-1] ^ offset_i;
      end
      WID_20: begin
        code_o[19:0] = raw_i[RAW_W-1 -: 20];
        code_o[19]   = raw_i[RAW_W-1] ^ offset_i;
      end
      default: begin
        code_o         = raw_i;
        code_o[RAW_W-1] = raw_i[RAW_W-1] ^ offset_i;
      end
    endcase
  end
endmodule

// File: rtl/sfc_ram.sv
module sfc_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        ovf_set_i,
  input  logic        unf_set_i,
  output ctrl_t       ctrl_o,
  output logic [31:0] rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      ctrl_q.thr <= THR_RST;
    end else begin
      ctrl_q.clr <= wr_i & wdata_i[CLR_BIT];
      if (wr_i) begin
        ctrl_q.thr <= wdata_i[THR_W-1:0];
        ctrl_q.dis <= wdata_i[DIS_BIT];
        ctrl_q.wid <= wid_e'(wdata_i[WID_LSB +: 2]);
      end
      ctrl_q.ovf <= ovf_set_i | (ctrl_q.ovf & ~(wr_i & ~wdata_i[OVF_BIT]));
      ctrl_q.unf <= unf_set_i | (ctrl_q.unf & ~(wr_i & ~wdata_i[UNF_BIT]));
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {6'b0, ctrl_q.unf, ctrl_q.ovf, 2'b0, ctrl_q.wid,
                    ctrl_q.clr, ctrl_q.dis, ctrl_q.thr};

  // R7: the clear bit drops back after one cycle unless written again
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.clr && !(wr_i && wdata_i[CLR_BIT])) |=> !ctrl_q.clr);
  // R8: a full-buffer arrival raises the overflow flag
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_set_i |=> ctrl_q.ovf);
  // R9: an empty-buffer pop raises the underflow flag
  p_unf_set_r9: assert property (@(posedge clk) disable iff (rst)
    unf_set_i |=> ctrl_q.unf);
  // R10: flags hold until a write puts zero in them
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ovf && !(wr_i && !wdata_i[OVF_BIT])) |=> ctrl_q.ovf);
  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.unf && !(wr_i && !wdata_i[UNF_BIT])) |=> ctrl_q.unf);
endmodule

// File: rtl/sample_fifo_ctl.sv
module sample_fifo_ctl
  import sfc_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                offset_bin,
  input  logic                smp_valid,
  input  logic [TAG_W-1:0]    smp_chan,
  input  logic [RAW_W-1:0]    smp_data,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                pop,
  output logic [WORD_W-1:0]   pop_data,
  output logic [CNT_W-1:0]    fill_count,
  output logic                thresh_flag
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  ctrl_t             ctrl;
  logic [AW-1:0]     wptr, rptr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [RAW_W-1:0]  code;
  logic [WORD_W-1:0] word, ram_q;
  logic [THR_W-1:0]  thr_nxt;
  logic              full, empty, push_req, push_ok, pop_ok;
  logic              ovf_set, unf_set, clr_now, zero_q, flag_q;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign empty    = (cnt == '0);
  assign push_req = smp_valid & ~ctrl.dis;
  assign push_ok  = push_req & ~full;
  assign pop_ok   = pop & ~empty;
  assign ovf_set  = push_req & full;
  assign unf_set  = pop & empty;
  assign clr_now  = reg_wr & reg_wdata[CLR_BIT];

  sfc_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .wdata_i(reg_wdata),
    .ovf_set_i(ovf_set), .unf_set_i(unf_set),
    .ctrl_o(ctrl), .rdata_o(reg_rdata)
  );

  sfc_coder u_coder (
    .raw_i(smp_data), .wid_i(ctrl.wid), .offset_i(offset_bin), .code_o(code)
  );

  assign word = {{(WORD_W-TAG_LSB-TAG_W){1'b0}}, smp_chan, code};

  sfc_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(word),
    .re(pop_ok), .raddr(rptr), .rdata(ram_q)
  );

  always_comb begin
    if (clr_now) cnt_nxt = '0;
    else         cnt_nxt = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    thr_nxt = reg_wr ? reg_wdata[THR_W-1:0] : ctrl.thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      flag_q <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      if (clr_now) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_ok) wptr <= wptr + 1'b1;
        if (pop_ok)  rptr <= rptr + 1'b1;
      end
      cnt    <= cnt_nxt;
      flag_q <= CMP_W'(cnt_nxt) > CMP_W'(thr_nxt);
      if (pop) zero_q <= empty;
    end
  end

  assign pop_data    = zero_q ? '0 : ram_q;
  assign fill_count  = cnt;
  assign thresh_flag = flag_q;

  // R12: the count never passes the capacity
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  // R5: the flag matches the comparison of count and threshold
  p_thresh_r5: assert property (@(posedge clk) disable iff (rst)
    thresh_flag == (CMP_W'(fill_count) > CMP_W'(ctrl.thr)));
  // R8: an arrival on full leaves count and write position alone
  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop && !clr_now) |=> (cnt == CNT_W'(DEPTH)) && $stable(wptr));
  // R9: an empty pop returns zero and the read position stays
  p_unf_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> pop_data == '0);
  p_unf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !clr_now) |=> $stable(rptr));
  // R6: blocked samples do not raise the count
  p_dis_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dis && !pop && !clr_now) |=> cnt == $past(cnt));
endmodule

// File: tb/sample_fifo_ctl_test.sv
module sample_fifo_ctl_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1, offset_bin = 0, smp_valid = 0, reg_wr = 0, pop = 0;
  logic [4:0]  smp_chan = '0;
  logic [23:0] smp_data = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, pop_data;
  logic [CNT_W-1:0] fill_count;
  logic thresh_flag;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sample_fifo_ctl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .offset_bin(offset_bin), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop),
    .pop_data(pop_data), .fill_count(fill_count), .thresh_flag(thresh_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(input logic [17:0] thr, input logic dis,
                                         input logic clr, input logic [1:0] wid,
                                         input logic ovf, input logic unf);
    return {6'b0, unf, ovf, 2'b0, wid, clr, dis, thr};
  endfunction

  function automatic logic [31:0] expword(input logic [23:0] raw, input logic [1:0] wid,
                                          input logic off, input logic [4:0] ch);
    int w;
    logic [23:0] v;
    w = (wid == 0) ? 16 : (wid == 1) ? 18 : (wid == 2) ? 20 : 24;
    v = raw >> (24 - w);
    if (off) v = v ^ (24'd1 << (w - 1));
    return {3'b0, ch, v};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic push(input logic [23:0] d, input logic [4:0] ch);
    @(negedge clk); smp_valid = 1; smp_data = d; smp_chan = ch;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", 32'(fill_count), 0);
    chk("R1 flag", 32'(thresh_flag), 0);
    chk("R1 reg", reg_rdata, 32'h0003FFFE);
    chk("R1 pop_data", pop_data, 0);
  endtask

  task automatic t_order();
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 1));
    offset_bin = 0;
    for (int i = 0; i < 3; i++) push(24'h5A0000 + 24'(i * 17), 5'(i + 4));
    chk("R12 count after 3 pushes", 32'(fill_count), 3);
    for (int i = 0; i < 3; i++) begin
      do_pop();
      chk("R2 order/layout", pop_data, expword(24'h5A0000 + 24'(i * 17), 3, 0, 5'(i + 4)));
    end
    chk("R12 count after pops", 32'(fill_count), 0);
  endtask

  task automatic t_width();
    logic [23:0] raws [3] = '{24'h123456, 24'hFFFFFF, 24'h000000};
    for (int off = 0; off < 2; off++) begin
      offset_bin = off[0];
      for (int w = 0; w < 4; w++) begin
        wr(mkctrl(18'h3FFFE, 0, 0, 2'(w), 1, 1));
        for (int r = 0; r < 3; r++) begin
          push(raws[r], 5'(w + 8 * r));
          do_pop();
          chk(off ? "R4 offset coding" : "R3 width", pop_data,
              expword(raws[r], 2'(w), off[0], 5'(w + 8 * r)));
        end
      end
    end
    offset_bin = 1;
    wr(mkctrl(18'h3FFFE, 0, 0, 0, 1, 1));
    push(24'h000000, 0); do_pop();
    chk("R4 zero in offset binary", pop_data, 32'h00008000);
    offset_bin = 0;
  endtask

  task automatic t_thresh();
    wr(mkctrl(18'd2, 0, 0, 3, 1, 1));
    for (int i = 1; i <= 3; i++) begin
      push(24'(i), 1);
      chk("R5 flag vs count", 32'(thresh_flag), (i > 2) ? 1 : 0);
    end
    do_pop();
    chk("R5 flag after pop to 2", 32'(thresh_flag), 0);
    wr(mkctrl(18'd1, 0, 0, 3, 1, 1));
    chk("R5 flag after threshold write", 32'(thresh_flag), 1);
    for (int i = 0; i < 2; i++) do_pop();
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 1));
  endtask

  task automatic t_disable();
    wr(mkctrl(18'h3FFFE, 1, 0, 3, 1, 1));
    push(24'h111111, 2);
    push(24'h222222, 3);
    chk("R6 blocked count", 32'(fill_count), 0);
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 1));
    push(24'h333333, 4);
    chk("R6 re-enabled count", 32'(fill_count), 1);
  endtask

  task automatic t_clear();
    push(24'h444444, 5);
    @(negedge clk); reg_wr = 1; reg_wdata = mkctrl(18'h3FFFE, 0, 1, 3, 1, 1);
    @(negedge clk); reg_wr = 0;
    chk("R7 emptied", 32'(fill_count), 0);
    chk("R7 clear bit high one cycle", 32'(reg_rdata[19]), 1);
    @(negedge clk);
    chk("R7 clear bit self-clears", 32'(reg_rdata[19]), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(24'h100000 + 24'(i), 5'(i));
    push(24'hABCDEF, 31);
    chk("R8 count stays full", 32'(fill_count), DEPTH);
    chk("R8 overflow flag", 32'(reg_rdata[24]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      do_pop();
      if (i == 0 || i == DEPTH - 1)
        chk("R8 data intact", pop_data, expword(24'h100000 + 24'(i), 3, 0, 5'(i)));
    end
  endtask

  task automatic t_underflow();
    do_pop();
    chk("R9 empty pop zero", pop_data, 0);
    chk("R9 underflow flag", 32'(reg_rdata[25]), 1);
    push(24'h765432, 9);
    do_pop();
    chk("R9 pointer unmoved", pop_data, expword(24'h765432, 3, 0, 9));
  endtask

  task automatic t_sticky();
    wr(mkctrl(18'h3FFFE, 0, 1, 3, 1, 1));
    chk("R7 flags kept by clear", 32'(reg_rdata[25:24]), 3);
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 1));
    chk("R10 write 1 keeps flags", 32'(reg_rdata[25:24]), 3);
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 0));
    chk("R10 write 0 clears underflow only", 32'(reg_rdata[25:24]), 1);
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 0, 0));
    chk("R10 write 0 clears overflow", 32'(reg_rdata[25:24]), 0);
    wr(mkctrl(18'h3FFFE, 0, 0, 3, 1, 1));
    chk("R10 write 1 does not set", 32'(reg_rdata[25:24]), 0);
  endtask

  task automatic t_reserved();
    @(negedge clk); reg_wr = 1; reg_wdata = 32'hFFFFFFFF;
    @(negedge clk); reg_wr = 0;
    chk("R11 reserved zero", reg_rdata, 32'h003FFFFF);
    @(negedge clk);
    chk("R11 reserved zero after clear drops", reg_rdata, 32'h0037FFFF);
    wr(mkctrl(18'h3FFFE, 0, 0, 0, 1, 1));
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_order();
    t_width();
    t_thresh();
    t_disable();
    t_clear();
    t_overflow();
    t_underflow();
    t_sticky();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule